// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block owns the descriptor table of a packet MAC and walks two rings held in that table. A host bus port reads and writes every descriptor word and a single register that sets how many descriptors belong to the transmit ring. The remaining descriptors, starting at that count, form the receive ring. Each descriptor is a control/status word followed by a buffer address word. Ownership passes between software and hardware through one flag per descriptor: a ready flag on the transmit side and an empty flag on the receive side.

The transmit walker waits on its current descriptor until software marks it ready. It then offers the buffer address, the length and the per-frame pad and checksum options to a frame engine, and holds the offer until the engine reports completion. It writes the completion status back, hands the descriptor back to software and moves on. The receive walker continuously shows the frame engine whether its current descriptor is free and where that buffer lives. Each finished frame is recorded in the descriptor, or dropped with a busy event when no descriptor is free. Event pulses go to an interrupt controller outside this block. They are raised only for descriptors that ask for them.

Top module: `desc_ring_seq`

## Requirements
- R1: After reset the ring-count register reads 0x40, every descriptor word reads 0, `tx_req` is low, and all five event outputs are low.
- R2: On the host port, the ring-count register is at byte address 0x020 and descriptor i is at byte address 0x400+8*i (its control/status word) and 0x400+8*i+4 (its buffer address word). Read data is registered and appears on `host_rdata` in the cycle after the read request.
- R3: A ring-count value N written above 128 is stored as 128. Every write of the count restarts the transmit walker at index 0 and the receive walker at index N.
- R4: When the current transmit descriptor has bit 15 (ready) set, `tx_req` rises and carries the buffer address, `tx_len` = bits 31:16, `tx_pad` = bit 12 and `tx_crc` = bit 11. These values are held unchanged until `tx_done` is sampled high, and `tx_req` falls in the next cycle.
- R5: While the current transmit descriptor has bit 15 clear, the walker makes no request and does not advance. It re-examines that descriptor every cycle and issues the request once software sets bit 15.
- R6: On `tx_done`, the control word is rewritten. Bits 31:16 and 14:9 keep their values, bit 15 is cleared, and bits 8:0 take `tx_status`: bit 0 carrier lost, bit 1 deferred, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun.
- R7: If bit 14 (interrupt enable) of a completed transmit descriptor is set, one cycle after `tx_done` either `tx_frame_ev` or `tx_err_ev` pulses for one cycle. `tx_err_ev` is chosen when any of status bits 0, 2, 3 or 8 is set. With bit 14 clear, no transmit event is raised.
- R8: A descriptor with bit 13 (wrap) set ends its ring, and so does the last index of its region (N-1 for transmit, 127 for receive). After it, the transmit walker returns to index 0 and the receive walker to index N.
- R9: While the current receive descriptor has bit 15 (empty) set, `rx_buf_ok` is high and `rx_buf_addr` shows its address word. On `rx_valid`, the word is rewritten: bits 31:16 = `rx_len`, bit 15 cleared, bits 14:9 kept, bits 8:0 = `rx_status`. The status bits are: 0 late collision, 1 checksum error, 2 short, 3 too long, 4 dribble nibble, 5 invalid symbol, 6 overrun, 7 missed, 8 control frame. The walker then advances.
- R10: If bit 14 of a completed receive descriptor is set, one cycle later `rx_err_ev` pulses when any of status bits 0, 1, 2, 3, 5 or 6 is set, and `rx_frame_ev` pulses otherwise.
- R11: An `rx_valid` that arrives while `rx_buf_ok` is low raises `rx_busy_ev` one cycle later. No descriptor word changes and the receive walker stays where it is.
- R12: A transmit completion and a receive completion in the same cycle are both written back and both raise their events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after request |
| tx_req | output | 1 | Transmit job offered to frame engine |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append checksum |
| tx_done | input | 1 | Frame engine finished the offered job |
| tx_status | input | 9 | Transmit completion status |
| tx_frame_ev | output | 1 | Good transmit event pulse |
| tx_err_ev | output | 1 | Failed transmit event pulse |
| rx_buf_ok | output | 1 | Current receive descriptor is free |
| rx_buf_addr | output | 32 | Current receive buffer address |
| rx_valid | input | 1 | Frame engine delivers a received frame |
| rx_len | input | 16 | Received length |
| rx_status | input | 9 | Receive completion status |
| rx_frame_ev | output | 1 | Good receive event pulse |
| rx_err_ev | output | 1 | Failed receive event pulse |
| rx_busy_ev | output | 1 | Frame dropped, no free descriptor |

## Verification
The two walkers share one descriptor table and can both write a status word back on the same clock edge. The bench leaves a transmit job pending and refills a receive descriptor. It then raises `tx_done` and `rx_valid` in the same cycle. Both descriptor words are read back over the host port, and both event pulses are checked in the following cycle.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

   localparam int WORD_W = 32;
   localparam int STAT_W = 9;
   localparam int LEN_W  = 16;

   // control word flag positions, shared by both rings
   localparam int BIT_OWN  = 15;
   localparam int BIT_IRQ  = 14;
   localparam int BIT_WRAP = 13;
   localparam int BIT_PAD  = 12;
   localparam int BIT_CRC  = 11;

   // status bits that classify a completion as failed
   localparam logic [STAT_W-1:0] TX_ERR_MASK = 9'h10D;
   localparam logic [STAT_W-1:0] RX_ERR_MASK = 9'h06F;

   typedef enum logic {
      TXW_SCAN,
      TXW_BUSY
   } txw_state_e;

endpackage

// File: rtl/bdr_table.sv
module bdr_table
   import bdr_pkg::*;
#(
   parameter  int NUM_DESC  = 128,
   parameter  int DEF_COUNT = 64,
   parameter  int ADDR_W    = 11,
   parameter  int CNT_OFS   = 'h20,
   parameter  int TBL_BASE  = 'h400,
   localparam int IDX_W     = $clog2(NUM_DESC),
   localparam int CNT_W     = $clog2(NUM_DESC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic [CNT_W-1:0]  count,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_new,
   input  logic [IDX_W-1:0]  tx_idx,
   output logic [WORD_W-1:0] tx_stat,
   output logic [WORD_W-1:0] tx_addr,
   input  logic [IDX_W-1:0]  rx_idx,
   output logic [WORD_W-1:0] rx_stat,
   output logic [WORD_W-1:0] rx_addr,
   input  logic              tx_wb_en,
   input  logic [IDX_W-1:0]  tx_wb_idx,
   input  logic [WORD_W-1:0] tx_wb_data,
   input  logic              rx_wb_en,
   input  logic [IDX_W-1:0]  rx_wb_idx,
   input  logic [WORD_W-1:0] rx_wb_data
);

   logic [WORD_W-1:0] stat_mem [NUM_DESC];
   logic [WORD_W-1:0] addr_mem [NUM_DESC];

   logic [WORD_W-1:0] addr32;
   logic              in_tbl;
   logic              is_cnt;
   logic [IDX_W-1:0]  tbl_idx;
   logic              tbl_hi;
   logic              unused_lsb;

   always_comb begin
      addr32  = WORD_W'(host_addr);
      in_tbl  = (addr32 >= WORD_W'(TBL_BASE)) &&
                (addr32 <  WORD_W'(TBL_BASE + NUM_DESC * 8));
      is_cnt  = (addr32 == WORD_W'(CNT_OFS));
      tbl_idx = IDX_W'((addr32 - WORD_W'(TBL_BASE)) >> 3);
      tbl_hi  = host_addr[2];
   end
   assign unused_lsb = ^host_addr[1:0];

   assign cnt_wr  = host_req & host_we & is_cnt;
   assign cnt_new = (host_wdata > WORD_W'(NUM_DESC)) ? CNT_W'(NUM_DESC)
                                                      : host_wdata[CNT_W-1:0];

   // walker writebacks are placed after the host write so they take priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DESC; i++) begin
            stat_mem[i] <= '0;
            addr_mem[i] <= '0;
         end
         count <= CNT_W'(DEF_COUNT);
      end else begin
         if (host_req && host_we && in_tbl) begin
            if (tbl_hi) addr_mem[tbl_idx] <= host_wdata;
            else        stat_mem[tbl_idx] <= host_wdata;
         end
         if (tx_wb_en) stat_mem[tx_wb_idx] <= tx_wb_data;
         if (rx_wb_en) stat_mem[rx_wb_idx] <= rx_wb_data;
         if (cnt_wr)   count <= cnt_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_req && !host_we) begin
         if (in_tbl)      host_rdata <= tbl_hi ? addr_mem[tbl_idx] : stat_mem[tbl_idx];
         else if (is_cnt) host_rdata <= WORD_W'(count);
         else             host_rdata <= '0;
      end
   end

   assign tx_stat = stat_mem[tx_idx];
   assign tx_addr = addr_mem[tx_idx];
   assign rx_stat = stat_mem[rx_idx];
   assign rx_addr = addr_mem[rx_idx];

endmodule

// File: rtl/bdr_tx_walker.sv
module bdr_tx_walker
   import bdr_pkg::*;
#(
   parameter  int NUM_DESC = 128,
   localparam int IDX_W    = $clog2(NUM_DESC),
   localparam int CNT_W    = $clog2(NUM_DESC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic              restart,
   input  logic [WORD_W-1:0] cur_stat,
   input  logic [WORD_W-1:0] cur_addr,
   output logic [IDX_W-1:0]  idx,
   output logic              tx_req,
   output logic [WORD_W-1:0] tx_buf_addr,
   output logic [LEN_W-1:0]  tx_len,
   output logic              tx_pad,
   output logic              tx_crc,
   input  logic              tx_done,
   input  logic [STAT_W-1:0] tx_status,
   output logic              wb_en,
   output logic [WORD_W-1:0] wb_data,
   output logic              frame_ev,
   output logic              err_ev
);

   txw_state_e        state_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [IDX_W-1:0]  ptr_nxt;
   logic [WORD_W-1:0] lat_word_q;
   logic [WORD_W-1:0] lat_addr_q;
   logic              at_end;
   logic              failed;
   logic              unused_lat;

   assign at_end  = (WORD_W'(ptr_q) + WORD_W'(1)) >= WORD_W'(count);
   assign ptr_nxt = (lat_word_q[BIT_WRAP] || at_end) ? '0 : ptr_q + 1'b1;
   assign failed  = |(tx_status & TX_ERR_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TXW_SCAN;
         ptr_q      <= '0;
         lat_word_q <= '0;
         lat_addr_q <= '0;
         frame_ev   <= 1'b0;
         err_ev     <= 1'b0;
      end else begin
         frame_ev <= 1'b0;
         err_ev   <= 1'b0;
         case (state_q)
            TXW_SCAN: begin
               if (count != '0 && cur_stat[BIT_OWN]) begin
                  state_q    <= TXW_BUSY;
                  lat_word_q <= cur_stat;
                  lat_addr_q <= cur_addr;
               end
            end
            TXW_BUSY: begin
               if (tx_done) begin
                  state_q  <= TXW_SCAN;
                  ptr_q    <= ptr_nxt;
                  frame_ev <= lat_word_q[BIT_IRQ] & ~failed;
                  err_ev   <= lat_word_q[BIT_IRQ] &  failed;
               end
            end
            default: state_q <= TXW_SCAN;
         endcase
         if (restart) ptr_q <= '0;
      end
   end

   assign idx         = ptr_q;
   assign tx_req      = (state_q == TXW_BUSY);
   assign tx_buf_addr = lat_addr_q;
   assign tx_len      = lat_word_q[WORD_W-1:LEN_W];
   assign tx_pad      = lat_word_q[BIT_PAD];
   assign tx_crc      = lat_word_q[BIT_CRC];
   assign wb_en       = tx_req & tx_done;
   assign wb_data     = {lat_word_q[WORD_W-1:BIT_OWN+1], 1'b0,
                         lat_word_q[BIT_OWN-1:STAT_W], tx_status};
   assign unused_lat  = ^lat_word_q[STAT_W-1:0];

endmodule

// File: rtl/bdr_rx_walker.sv
module bdr_rx_walker
   import bdr_pkg::*;
#(
   parameter  int NUM_DESC  = 128,
   parameter  int DEF_COUNT = 64,
   localparam int IDX_W     = $clog2(NUM_DESC),
   localparam int CNT_W     = $clog2(NUM_DESC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic              restart,
   input  logic [CNT_W-1:0]  restart_base,
   input  logic [WORD_W-1:0] cur_stat,
   input  logic [WORD_W-1:0] cur_addr,
   output logic [IDX_W-1:0]  idx,
   output logic              rx_buf_ok,
   output logic [WORD_W-1:0] rx_buf_addr,
   input  logic              rx_valid,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [STAT_W-1:0] rx_status,
   output logic              wb_en,
   output logic [WORD_W-1:0] wb_data,
   output logic              frame_ev,
   output logic              err_ev,
   output logic              busy_ev
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_DESC - 1);

   logic [CNT_W-1:0] ptr_q;
   logic [CNT_W-1:0] ptr_nxt;
   logic             in_ring;
   logic             failed;
   logic             unused_stat;

   assign in_ring   = ptr_q < CNT_W'(NUM_DESC);
   assign idx       = ptr_q[IDX_W-1:0];
   assign rx_buf_ok = in_ring & cur_stat[BIT_OWN];
   assign rx_buf_addr = cur_addr;
   assign ptr_nxt   = (cur_stat[BIT_WRAP] || ptr_q == LAST) ? count : ptr_q + 1'b1;
   assign failed    = |(rx_status & RX_ERR_MASK);
   assign wb_en     = rx_valid & rx_buf_ok;
   assign wb_data   = {rx_len, 1'b0, cur_stat[BIT_OWN-1:STAT_W], rx_status};
   assign unused_stat = ^{cur_stat[WORD_W-1:BIT_OWN+1], cur_stat[STAT_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= CNT_W'(DEF_COUNT);
         frame_ev <= 1'b0;
         err_ev   <= 1'b0;
         busy_ev  <= 1'b0;
      end else begin
         frame_ev <= wb_en & cur_stat[BIT_IRQ] & ~failed;
         err_ev   <= wb_en & cur_stat[BIT_IRQ] &  failed;
         busy_ev  <= rx_valid & ~rx_buf_ok;
         if (wb_en)   ptr_q <= ptr_nxt;
         if (restart) ptr_q <= restart_base;
      end
   end

endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
   import bdr_pkg::*;
#(
   parameter int NUM_DESC  = 128,
   parameter int DEF_COUNT = 64,
   parameter int ADDR_W    = 11,
   parameter int CNT_OFS   = 'h20,
   parameter int TBL_BASE  = 'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              tx_req,
   output logic [31:0]       tx_buf_addr,
   output logic [15:0]       tx_len,
   output logic              tx_pad,
   output logic              tx_crc,
   input  logic              tx_done,
   input  logic [8:0]        tx_status,
   output logic              tx_frame_ev,
   output logic              tx_err_ev,
   output logic              rx_buf_ok,
   output logic [31:0]       rx_buf_addr,
   input  logic              rx_valid,
   input  logic [15:0]       rx_len,
   input  logic [8:0]        rx_status,
   output logic              rx_frame_ev,
   output logic              rx_err_ev,
   output logic              rx_busy_ev
);

   localparam int IDX_W = $clog2(NUM_DESC);
   localparam int CNT_W = $clog2(NUM_DESC + 1);

   generate
      if (NUM_DESC < 2 || NUM_DESC > 128) begin : g_bad_num
         $error("NUM_DESC must lie in 2..128");
      end
      if (DEF_COUNT > NUM_DESC) begin : g_bad_def
         $error("DEF_COUNT exceeds NUM_DESC");
      end
      if ((TBL_BASE % 8) != 0) begin : g_bad_base
         $error("TBL_BASE must be 8-byte aligned");
      end
      if (ADDR_W < $clog2(TBL_BASE + NUM_DESC * 8)) begin : g_bad_addr
         $error("ADDR_W too narrow for the descriptor table");
      end
   endgenerate

   logic [CNT_W-1:0]  tx_count;
   logic              cnt_wr;
   logic [CNT_W-1:0]  cnt_new;
   logic [IDX_W-1:0]  tx_idx, rx_idx;
   logic [WORD_W-1:0] tx_cur_stat, tx_cur_addr, rx_cur_stat, rx_cur_addr;
   logic              tx_wb_en, rx_wb_en;
   logic [WORD_W-1:0] tx_wb_data, rx_wb_data;

   bdr_table #(
      .NUM_DESC (NUM_DESC),
      .DEF_COUNT(DEF_COUNT),
      .ADDR_W   (ADDR_W),
      .CNT_OFS  (CNT_OFS),
      .TBL_BASE (TBL_BASE)
   ) i_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_req  (host_req),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .count     (tx_count),
      .cnt_wr    (cnt_wr),
      .cnt_new   (cnt_new),
      .tx_idx    (tx_idx),
      .tx_stat   (tx_cur_stat),
      .tx_addr   (tx_cur_addr),
      .rx_idx    (rx_idx),
      .rx_stat   (rx_cur_stat),
      .rx_addr   (rx_cur_addr),
      .tx_wb_en  (tx_wb_en),
      .tx_wb_idx (tx_idx),
      .tx_wb_data(tx_wb_data),
      .rx_wb_en  (rx_wb_en),
      .rx_wb_idx (rx_idx),
      .rx_wb_data(rx_wb_data)
   );

   bdr_tx_walker #(
      .NUM_DESC(NUM_DESC)
   ) i_tx_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (tx_count),
      .restart    (cnt_wr),
      .cur_stat   (tx_cur_stat),
      .cur_addr   (tx_cur_addr),
      .idx        (tx_idx),
      .tx_req     (tx_req),
      .tx_buf_addr(tx_buf_addr),
      .tx_len     (tx_len),
      .tx_pad     (tx_pad),
      .tx_crc     (tx_crc),
      .tx_done    (tx_done),
      .tx_status  (tx_status),
      .wb_en      (tx_wb_en),
      .wb_data    (tx_wb_data),
      .frame_ev   (tx_frame_ev),
      .err_ev     (tx_err_ev)
   );

   bdr_rx_walker #(
      .NUM_DESC (NUM_DESC),
      .DEF_COUNT(DEF_COUNT)
   ) i_rx_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .count       (tx_count),
      .restart     (cnt_wr),
      .restart_base(cnt_new),
      .cur_stat    (rx_cur_stat),
      .cur_addr    (rx_cur_addr),
      .idx         (rx_idx),
      .rx_buf_ok   (rx_buf_ok),
      .rx_buf_addr (rx_buf_addr),
      .rx_valid    (rx_valid),
      .rx_len      (rx_len),
      .rx_status   (rx_status),
      .wb_en       (rx_wb_en),
      .wb_data     (rx_wb_data),
      .frame_ev    (rx_frame_ev),
      .err_ev      (rx_err_ev),
      .busy_ev     (rx_busy_ev)
   );

endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
   parameter int NUM_DESC = 128,
   parameter int CNT_W    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tx_count,
   input logic             tx_req,
   input logic             tx_done,
   input logic [31:0]      tx_buf_addr,
   input logic [15:0]      tx_len,
   input logic             tx_frame_ev,
   input logic             tx_err_ev,
   input logic             rx_valid,
   input logic             rx_buf_ok,
   input logic             rx_frame_ev,
   input logic             rx_err_ev,
   input logic             rx_busy_ev
);

   // R3: the stored ring count never exceeds the table size
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(NUM_DESC));

   // R4: an offered job stays put until the engine completes it
   a_r4_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done |=> tx_req && $stable(tx_buf_addr) && $stable(tx_len));

   // R4: the offer is withdrawn right after completion
   a_r4_offer_drops: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && tx_done |=> !tx_req);

   // R7: a transmit event only follows a completed offer, and never both kinds
   a_r7_tx_ev_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_frame_ev || tx_err_ev) |-> $past(tx_req && tx_done));

   a_r7_tx_ev_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_frame_ev, tx_err_ev}));

   // R10: a receive event only follows an accepted frame
   a_r10_rx_ev_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_frame_ev || rx_err_ev) |-> $past(rx_valid && rx_buf_ok));

   // R11: a frame with no free descriptor yields busy and nothing else
   a_r11_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_buf_ok |=> rx_busy_ev && !rx_frame_ev && !rx_err_ev);

endmodule

bind desc_ring_seq bdr_checker #(
   .NUM_DESC(NUM_DESC),
   .CNT_W   (CNT_W)
) i_bdr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_count   (tx_count),
   .tx_req     (tx_req),
   .tx_done    (tx_done),
   .tx_buf_addr(tx_buf_addr),
   .tx_len     (tx_len),
   .tx_frame_ev(tx_frame_ev),
   .tx_err_ev  (tx_err_ev),
   .rx_valid   (rx_valid),
   .rx_buf_ok  (rx_buf_ok),
   .rx_frame_ev(rx_frame_ev),
   .rx_err_ev  (rx_err_ev),
   .rx_busy_ev (rx_busy_ev)
);

// File: tb/test_desc_ring_seq.sv
`timescale 1ns / 100ps

module test_desc_ring_seq;

   localparam int ADDR_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_req = 1'b0;
   logic              host_we = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [31:0]       host_wdata = '0;
   logic [31:0]       host_rdata;
   logic              tx_req;
   logic [31:0]       tx_buf_addr;
   logic [15:0]       tx_len;
   logic              tx_pad, tx_crc;
   logic              tx_done = 1'b0;
   logic [8:0]        tx_status = '0;
   logic              tx_frame_ev, tx_err_ev;
   logic              rx_buf_ok;
   logic [31:0]       rx_buf_addr;
   logic              rx_valid = 1'b0;
   logic [15:0]       rx_len = '0;
   logic [8:0]        rx_status = '0;
   logic              rx_frame_ev, rx_err_ev, rx_busy_ev;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   desc_ring_seq #(.ADDR_W(ADDR_W)) i_desc_ring_seq (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
      .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
      .tx_frame_ev(tx_frame_ev), .tx_err_ev(tx_err_ev),
      .rx_buf_ok(rx_buf_ok), .rx_buf_addr(rx_buf_addr), .rx_valid(rx_valid),
      .rx_len(rx_len), .rx_status(rx_status),
      .rx_frame_ev(rx_frame_ev), .rx_err_ev(rx_err_ev), .rx_busy_ev(rx_busy_ev)
   );

   typedef struct packed {
      logic [7:0]  idx;
      logic [31:0] ctrl;
      logic [31:0] baddr;
      logic [8:0]  tstat;
      logic [31:0] expw;
      logic        good;
      logic        bad;
   } tx_vec_t;

   // ring count 4: index 1 carries wrap in v1, index 3 ends the region in v5
   localparam tx_vec_t TXV [6] = '{
      '{8'd0, 32'h0040_C800, 32'h1000_0000, 9'h000, 32'h0040_4800, 1'b1, 1'b0},
      '{8'd1, 32'h05DC_F000, 32'h2000_0100, 9'h108, 32'h05DC_7108, 1'b0, 1'b1},
      '{8'd0, 32'h003C_8000, 32'h3000_0000, 9'h034, 32'h003C_0034, 1'b0, 1'b0},
      '{8'd1, 32'h0100_C000, 32'h4000_0000, 9'h0F2, 32'h0100_40F2, 1'b1, 1'b0},
      '{8'd2, 32'h0200_D800, 32'h5000_0000, 9'h001, 32'h0200_5801, 1'b0, 1'b1},
      '{8'd3, 32'h0080_C000, 32'h6000_0000, 9'h000, 32'h0080_4000, 1'b1, 1'b0}
   };

   function automatic logic [ADDR_W-1:0] dadr(input int idx, input int hi);
      return ADDR_W'(32'h400 + idx * 8 + hi * 4);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b0; host_addr = a;
      @(negedge clk);
      host_req = 1'b0;
      d = host_rdata;
   endtask

   task automatic wait_tx_req(output bit got);
      got = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (tx_req) begin
            got = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic rx_frame(input logic [15:0] len, input logic [8:0] st);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = len; rx_status = st;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      bit          got;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 tx_req", 32'(tx_req), 32'd0);
      chk("R1 events", 32'({tx_frame_ev, tx_err_ev, rx_frame_ev, rx_err_ev, rx_busy_ev}), 32'd0);
      host_read(11'h020, rd);
      chk("R1 count reset", rd, 32'h40);
      host_read(dadr(0, 0), rd);
      chk("R1 table word", rd, 32'h0);

      // R3: count write restarts the rings at 0 and N
      host_write(11'h020, 32'd4);
      host_read(11'h020, rd);
      chk("R3 count readback", rd, 32'd4);
      host_write(dadr(4, 1), 32'h0000_A000);
      host_write(dadr(4, 0), 32'h0000_C000);
      host_write(dadr(5, 1), 32'h0000_B000);
      host_write(dadr(5, 0), 32'h0000_E000);
      chk("R9 rx_buf_ok", 32'(rx_buf_ok), 32'd1);
      chk("R3 rx base addr", rx_buf_addr, 32'h0000_A000);

      // R4 R6 R7 R8: transmit vector walk
      for (int v = 0; v < 6; v++) begin
         host_write(dadr(int'(TXV[v].idx), 1), TXV[v].baddr);
         host_write(dadr(int'(TXV[v].idx), 0), TXV[v].ctrl);
         wait_tx_req(got);
         chk("R4 R8 tx_req raised", 32'(got), 32'd1);
         chk("R4 tx_buf_addr", tx_buf_addr, TXV[v].baddr);
         chk("R4 tx_len", 32'(tx_len), 32'(TXV[v].ctrl[31:16]));
         chk("R4 pad crc", 32'({tx_pad, tx_crc}), 32'(TXV[v].ctrl[12:11]));
         tx_done = 1'b1; tx_status = TXV[v].tstat;
         @(negedge clk);
         tx_done = 1'b0;
         chk("R7 tx_frame_ev", 32'(tx_frame_ev), 32'(TXV[v].good));
         chk("R7 tx_err_ev", 32'(tx_err_ev), 32'(TXV[v].bad));
         chk("R4 tx_req falls", 32'(tx_req), 32'd0);
         host_read(dadr(int'(TXV[v].idx), 0), rd);
         chk("R6 tx writeback", rd, TXV[v].expw);
      end

      // R2: address word location
      host_read(dadr(1, 1), rd);
      chk("R2 address word", rd, 32'h4000_0000);

      // R9 R10: good control frame into index 4
      rx_frame(16'h0200, 9'h100);
      chk("R10 rx_frame_ev", 32'({rx_frame_ev, rx_err_ev}), 32'b10);
      chk("R9 rx advance", rx_buf_addr, 32'h0000_B000);
      host_read(dadr(4, 0), rd);
      chk("R9 rx writeback", rd, 32'h0200_4100);

      // R10 R8: checksum error into index 5, wrap back to N
      rx_frame(16'h0080, 9'h002);
      chk("R10 rx_err_ev", 32'({rx_frame_ev, rx_err_ev}), 32'b01);
      chk("R8 rx wrap", rx_buf_addr, 32'h0000_A000);
      chk("R11 not free", 32'(rx_buf_ok), 32'd0);
      host_read(dadr(5, 0), rd);
      chk("R9 rx writeback wrap", rd, 32'h0080_6002);

      // R11: drop while index 4 is still owned by software
      rx_frame(16'h0333, 9'h000);
      chk("R11 busy", 32'({rx_busy_ev, rx_frame_ev, rx_err_ev}), 32'b100);
      host_read(dadr(4, 0), rd);
      chk("R11 desc unchanged", rd, 32'h0200_4100);
      chk("R11 ptr held", rx_buf_addr, 32'h0000_A000);

      // R5: stall on index 0 without ready
      host_write(dadr(0, 1), 32'h7000_0000);
      host_write(dadr(0, 0), 32'h0010_4000);
      got = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (tx_req) got = 1'b1;
      end
      chk("R5 stalled", 32'(got), 32'd0);
      host_write(dadr(0, 0), 32'h0010_C000);
      wait_tx_req(got);
      chk("R5 resumes", 32'(got), 32'd1);
      chk("R5 resumed addr", tx_buf_addr, 32'h7000_0000);

      // R12: both completions in one cycle
      host_write(dadr(4, 0), 32'h0000_C000);
      @(negedge clk);
      tx_done = 1'b1; tx_status = 9'h000;
      rx_valid = 1'b1; rx_len = 16'h0044; rx_status = 9'h000;
      @(negedge clk);
      tx_done = 1'b0; rx_valid = 1'b0;
      chk("R12 both events", 32'({tx_frame_ev, rx_frame_ev}), 32'b11);
      host_read(dadr(0, 0), rd);
      chk("R12 tx word", rd, 32'h0010_4000);
      host_read(dadr(4, 0), rd);
      chk("R12 rx word", rd, 32'h0044_4000);

      // R3: clamp above 128 leaves no receive ring
      host_write(11'h020, 32'h0000_0200);
      host_read(11'h020, rd);
      chk("R3 clamp", rd, 32'h80);
      chk("R3 no rx ring", 32'(rx_buf_ok), 32'd0);
      rx_frame(16'h0010, 9'h000);
      chk("R11 busy no ring", 32'(rx_busy_ev), 32'd1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule